// File: doc/BRIEF.md
# Outbound Read Prefetch Controller

This block sits between a local CPU-side bus and an external memory region reached over a PCI-style master port. The local side is a 32-bit slave, so a 64-bit processor load arrives as a pair of 32-bit conversion requests. Each request carries an attribute bit that marks its target region as either prefetchable or not, and that bit picks one of two paths through the block.

On the passthrough path, used for regions that are not prefetchable, every 32-bit read turns into exactly one single-beat external read. Its data goes straight back to the requester. On the prefetch path, a read that misses the line buffer issues one read-multiple of a whole 64-byte aligned line. The returned beats fill a 16-word buffer tagged with the line base, and every later read inside that line is answered from the buffer without any external cycle. Writes are forwarded as single-beat external writes. A write that lands in the buffered line drops the line, so the next prefetchable read of it fetches fresh data.

Top module: `opf_read_prefetch`

## Requirements
- R1: A read with `loc_pref`=0 issues one external command with `ext_cmd_burst`=0 and `ext_cmd_write`=0 at the request address, and completes with the single returned beat, so a 64-bit read costs two such commands.
- R2: Reads with `loc_pref`=0 neither fill nor hit the line buffer: a read of a buffered word with `loc_pref`=0 still issues a single-beat external read, and the buffered line stays valid.
- R3: A read with `loc_pref`=1 that misses issues one command with `ext_cmd_burst`=1 at the 64-byte aligned address (address bits 5:0 zero), and no single-beat read.
- R4: A read with `loc_pref`=1 that hits is acknowledged in the first cycle it is presented, with no external command.
- R5: Sixteen 32-bit reads (eight 64-bit reads) covering one aligned 64-byte line with `loc_pref`=1 cause exactly one read-multiple in total.
- R6: A read with `loc_pref`=1 outside the buffered line replaces the line through a new read-multiple, and a return to the old line refetches it.
- R7: A write issues one command with `ext_cmd_write`=1 and `ext_cmd_burst`=0 and is acknowledged when that command is accepted. A write into the buffered line invalidates it, so the next read of that line refetches and returns the written data.
- R8: A write outside the buffered line leaves the buffer valid: a later read in the line hits with no external command.
- R9: Beat k of a read-multiple (k = 0 to 15) is stored as the word at byte offset 4k of the line, and reads return that word.
- R10: While and right after reset, no external command or local acknowledge is driven, and the buffer holds no valid line.
- R11: Once `ext_cmd_valid` is raised, it and the command fields stay unchanged until `ext_cmd_ready` accepts the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| loc_valid | input | 1 | Local request present, held until `loc_ready` |
| loc_we | input | 1 | Request is a write |
| loc_addr | input | 32 | Byte address, word aligned |
| loc_wdata | input | 32 | Write data |
| loc_pref | input | 1 | Target region is prefetchable |
| loc_ready | output | 1 | Request completes this cycle |
| loc_rdata | output | 32 | Read data, valid with `loc_ready` on reads |
| ext_cmd_valid | output | 1 | External command pending |
| ext_cmd_ready | input | 1 | External side accepts the command |
| ext_cmd_addr | output | 32 | External byte address |
| ext_cmd_write | output | 1 | Command is a single-beat write |
| ext_cmd_burst | output | 1 | Command is a 16-beat read-multiple |
| ext_cmd_wdata | output | 32 | Write data for a write command |
| ext_rvalid | input | 1 | Read beat returned |
| ext_rdata | input | 32 | Read beat data |

## Verification
The assertions assume that the requester holds `loc_valid`, `loc_we`, `loc_addr`, `loc_wdata` and `loc_pref` steady from the time it raises the request until the acknowledge cycle. They also assume that the external side returns beats only after it has accepted a read: one beat for a single read and sixteen back-to-back beats for a read-multiple. The bench driver keeps each request unchanged until it sees `loc_ready` and only then moves to the next one. The bench's external responder raises `ext_cmd_ready` for one cycle and then streams exactly the number of beats that the accepted command calls for, so these assumptions hold for the whole run.

// File: rtl/opf_pkg.sv
// Package: shared types for the outbound read prefetch controller.
// Assumes nothing beyond being compiled ahead of the modules that import it.
package opf_pkg;

    // Controller sequencing states
    typedef enum logic [2:0] {
        ST_IDLE,   // accept a new local request or answer a hit
        ST_RCMD,   // single-beat read command outstanding
        ST_RDAT,   // waiting for the single read beat
        ST_FCMD,   // line-fill read-multiple command outstanding
        ST_FDAT,   // collecting line-fill beats
        ST_WCMD    // single-beat write command outstanding
    } opf_state_e;

endpackage

// File: rtl/opf_line_buf.sv
// Module: opf_line_buf
// Holds one prefetched line (WORDS data words) with its tag and valid bit.
// Reads are combinational by word index; the hit flag compares a lookup tag.
// Assumes fill_start precedes exactly WORDS fill_we pulses, the last one
// marked by fill_done, and that inval never coincides with a fill.
module opf_line_buf #(
    parameter int DATA_W = 32,
    parameter int WORDS  = 16,
    parameter int TAG_W  = 26,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fill_start,
    input  logic [TAG_W-1:0]  fill_tag,
    input  logic              fill_we,
    input  logic [IDX_W-1:0]  fill_idx,
    input  logic [DATA_W-1:0] fill_data,
    input  logic              fill_done,
    input  logic              inval,
    input  logic [TAG_W-1:0]  lookup_tag,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              hit,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] words_q [WORDS];
    logic [TAG_W-1:0]  tag_q;
    logic              valid_q;

    // Data storage: each fill beat lands at its own word slot
    always_ff @(posedge clk) begin
        if (fill_we) begin
            words_q[fill_idx] <= fill_data;
        end
    end

    // Tag and valid: cleared on reset, fill start or invalidation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
        end else if (fill_start) begin
            valid_q <= 1'b0;
            tag_q   <= fill_tag;
        end else if (inval) begin
            valid_q <= 1'b0;
        end else if (fill_done) begin
            valid_q <= 1'b1;
        end
    end

    // Lookup: hit needs a valid line with a matching tag
    always_comb begin
        hit     = valid_q && (tag_q == lookup_tag);
        rd_data = words_q[rd_idx];
    end

    // Checker-side beat count since the fill began
    logic [IDX_W:0] chk_beats;
    always_ff @(posedge clk) begin
        if (!rst_n || fill_start) begin
            chk_beats <= '0;
        end else if (fill_we) begin
            chk_beats <= chk_beats + (IDX_W+1)'(1);
        end
    end

    // R9: a line turns valid only on its final beat, after all earlier ones
    p_full_line_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_done |-> (fill_we && chk_beats == (IDX_W+1)'(WORDS-1)));

    // R10: the buffer never reports a hit in the cycle after reset
    p_empty_after_reset_r10: assert property (@(posedge clk)
        !rst_n |=> !hit);

endmodule

// File: rtl/opf_ctrl.sv
// Module: opf_ctrl
// Sequences local requests: passthrough single reads, line fills on
// prefetchable misses, buffer hits and single-beat writes.
// Assumes local request fields stay stable while loc_valid waits for
// loc_ready, and the external side returns beats only for accepted reads.
module opf_ctrl
    import opf_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 64,
    localparam int BYTE_OFF  = $clog2(DATA_W/8),
    localparam int LINE_OFF  = $clog2(LINE_BYTES),
    localparam int WORDS     = LINE_BYTES / (DATA_W/8),
    localparam int IDX_W     = LINE_OFF - BYTE_OFF,
    localparam int TAG_W     = ADDR_W - LINE_OFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_valid,
    input  logic              loc_we,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [DATA_W-1:0] loc_wdata,
    input  logic              loc_pref,
    output logic              loc_ready,
    output logic [DATA_W-1:0] loc_rdata,
    output logic              ext_cmd_valid,
    input  logic              ext_cmd_ready,
    output logic [ADDR_W-1:0] ext_cmd_addr,
    output logic              ext_cmd_write,
    output logic              ext_cmd_burst,
    output logic [DATA_W-1:0] ext_cmd_wdata,
    input  logic              ext_rvalid,
    input  logic [DATA_W-1:0] ext_rdata,
    input  logic              buf_hit,
    input  logic [DATA_W-1:0] buf_rdata,
    output logic              fill_start,
    output logic [TAG_W-1:0]  fill_tag,
    output logic              fill_we,
    output logic [IDX_W-1:0]  fill_idx,
    output logic              fill_done,
    output logic              inval,
    output logic [TAG_W-1:0]  lookup_tag,
    output logic [IDX_W-1:0]  rd_idx
);

    opf_state_e        state_q;
    logic [IDX_W-1:0]  beat_q;
    logic              idle_rd;

    // Address split and idle-cycle decode for the buffer
    always_comb begin
        lookup_tag = loc_addr[ADDR_W-1:LINE_OFF];
        rd_idx     = loc_addr[LINE_OFF-1:BYTE_OFF];
        fill_tag   = lookup_tag;
        idle_rd    = (state_q == ST_IDLE) && loc_valid && !loc_we;
        fill_start = idle_rd && loc_pref && !buf_hit;
        inval      = (state_q == ST_IDLE) && loc_valid && loc_we && buf_hit;
        fill_we    = (state_q == ST_FDAT) && ext_rvalid;
        fill_idx   = beat_q;
        fill_done  = fill_we && (beat_q == IDX_W'(WORDS-1));
    end

    // Local handshake and external command strobe per state
    always_comb begin
        loc_ready = 1'b0;
        loc_rdata = buf_rdata;
        unique case (state_q)
            ST_IDLE: loc_ready = idle_rd && loc_pref && buf_hit;
            ST_RDAT: begin
                loc_ready = ext_rvalid;
                loc_rdata = ext_rdata;
            end
            ST_WCMD: loc_ready = ext_cmd_ready;
            default: loc_ready = 1'b0;
        endcase
        ext_cmd_valid = (state_q == ST_RCMD) || (state_q == ST_FCMD) ||
                        (state_q == ST_WCMD);
    end

    // State, command fields and fill beat counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q       <= ST_IDLE;
            beat_q        <= '0;
            ext_cmd_addr  <= '0;
            ext_cmd_write <= 1'b0;
            ext_cmd_burst <= 1'b0;
            ext_cmd_wdata <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (loc_valid) begin
                    ext_cmd_wdata <= loc_wdata;
                    ext_cmd_write <= loc_we;
                    ext_cmd_burst <= 1'b0;
                    ext_cmd_addr  <= loc_addr;
                    if (loc_we) begin
                        state_q <= ST_WCMD;
                    end else if (!loc_pref) begin
                        state_q <= ST_RCMD;
                    end else if (!buf_hit) begin
                        ext_cmd_burst <= 1'b1;
                        ext_cmd_addr  <= {loc_addr[ADDR_W-1:LINE_OFF],
                                          {LINE_OFF{1'b0}}};
                        beat_q        <= '0;
                        state_q       <= ST_FCMD;
                    end
                end
                ST_RCMD: if (ext_cmd_ready) state_q <= ST_RDAT;
                ST_RDAT: if (ext_rvalid)    state_q <= ST_IDLE;
                ST_FCMD: if (ext_cmd_ready) state_q <= ST_FDAT;
                ST_FDAT: if (ext_rvalid) begin
                    beat_q <= beat_q + IDX_W'(1);
                    if (fill_done) state_q <= ST_IDLE;
                end
                ST_WCMD: if (ext_cmd_ready) state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R11: a waiting command keeps its strobe and fields
    p_cmd_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cmd_valid && !ext_cmd_ready) |=>
            (ext_cmd_valid && $stable(ext_cmd_addr) &&
             $stable(ext_cmd_write) && $stable(ext_cmd_burst)));

    // R3: every read-multiple starts on a line boundary
    p_burst_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cmd_valid && ext_cmd_burst) |-> (ext_cmd_addr[LINE_OFF-1:0] == '0));

    // R3: prefetchable reads only ever go out as read-multiples
    p_pref_is_burst_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cmd_valid && !ext_cmd_write && loc_pref) |-> ext_cmd_burst);

    // R2: a single-beat read only serves a non-prefetchable request
    p_single_nopref_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cmd_valid && !ext_cmd_write && !ext_cmd_burst) |-> !loc_pref);

    // R7: writes are never bursts
    p_write_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_cmd_valid && ext_cmd_write) |-> !ext_cmd_burst);

    // R4: an acknowledge only answers a present request
    p_ack_needs_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        loc_ready |-> loc_valid);

    // R10: reset leaves both ports quiet
    p_reset_quiet_r10: assert property (@(posedge clk)
        !rst_n |=> (!ext_cmd_valid && !loc_ready));

endmodule

// File: rtl/opf_read_prefetch.sv
// Module: opf_read_prefetch (top)
// Outbound read path with a region-selected split between single-beat
// passthrough reads and a one-line prefetch buffer.
// Assumes a word-aligned loc_addr and the handshake rules of opf_ctrl.
module opf_read_prefetch #(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_valid,
    input  logic              loc_we,
    input  logic [ADDR_W-1:0] loc_addr,
    input  logic [DATA_W-1:0] loc_wdata,
    input  logic              loc_pref,
    output logic              loc_ready,
    output logic [DATA_W-1:0] loc_rdata,
    output logic              ext_cmd_valid,
    input  logic              ext_cmd_ready,
    output logic [ADDR_W-1:0] ext_cmd_addr,
    output logic              ext_cmd_write,
    output logic              ext_cmd_burst,
    output logic [DATA_W-1:0] ext_cmd_wdata,
    input  logic              ext_rvalid,
    input  logic [DATA_W-1:0] ext_rdata
);

    localparam int BYTE_OFF = $clog2(DATA_W/8);
    localparam int LINE_OFF = $clog2(LINE_BYTES);
    localparam int WORDS    = LINE_BYTES / (DATA_W/8);
    localparam int IDX_W    = LINE_OFF - BYTE_OFF;
    localparam int TAG_W    = ADDR_W - LINE_OFF;

    logic              buf_hit;
    logic [DATA_W-1:0] buf_rdata;
    logic              fill_start, fill_we, fill_done, inval;
    logic [TAG_W-1:0]  fill_tag, lookup_tag;
    logic [IDX_W-1:0]  fill_idx, rd_idx;

    opf_ctrl #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_BYTES(LINE_BYTES)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .loc_valid(loc_valid), .loc_we(loc_we), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_pref(loc_pref),
        .loc_ready(loc_ready), .loc_rdata(loc_rdata),
        .ext_cmd_valid(ext_cmd_valid), .ext_cmd_ready(ext_cmd_ready),
        .ext_cmd_addr(ext_cmd_addr), .ext_cmd_write(ext_cmd_write),
        .ext_cmd_burst(ext_cmd_burst), .ext_cmd_wdata(ext_cmd_wdata),
        .ext_rvalid(ext_rvalid), .ext_rdata(ext_rdata),
        .buf_hit(buf_hit), .buf_rdata(buf_rdata),
        .fill_start(fill_start), .fill_tag(fill_tag), .fill_we(fill_we),
        .fill_idx(fill_idx), .fill_done(fill_done), .inval(inval),
        .lookup_tag(lookup_tag), .rd_idx(rd_idx)
    );

    opf_line_buf #(
        .DATA_W(DATA_W), .WORDS(WORDS), .TAG_W(TAG_W)
    ) u_buf (
        .clk(clk), .rst_n(rst_n),
        .fill_start(fill_start), .fill_tag(fill_tag), .fill_we(fill_we),
        .fill_idx(fill_idx), .fill_data(ext_rdata), .fill_done(fill_done),
        .inval(inval), .lookup_tag(lookup_tag), .rd_idx(rd_idx),
        .hit(buf_hit), .rd_data(buf_rdata)
    );

endmodule

// File: tb/opf_read_prefetch_tb.sv
`timescale 1ns/1ps
module opf_read_prefetch_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        loc_valid = 1'b0, loc_we = 1'b0, loc_pref = 1'b0;
    logic [31:0] loc_addr = '0, loc_wdata = '0;
    logic        loc_ready;
    logic [31:0] loc_rdata;
    logic        ext_cmd_valid, ext_cmd_write, ext_cmd_burst;
    logic [31:0] ext_cmd_addr, ext_cmd_wdata;
    logic        ext_cmd_ready = 1'b0, ext_rvalid = 1'b0;
    logic [31:0] ext_rdata = '0;

    always #4 clk = ~clk;

    opf_read_prefetch u_dut (
        .clk(clk), .rst_n(rst_n),
        .loc_valid(loc_valid), .loc_we(loc_we), .loc_addr(loc_addr),
        .loc_wdata(loc_wdata), .loc_pref(loc_pref),
        .loc_ready(loc_ready), .loc_rdata(loc_rdata),
        .ext_cmd_valid(ext_cmd_valid), .ext_cmd_ready(ext_cmd_ready),
        .ext_cmd_addr(ext_cmd_addr), .ext_cmd_write(ext_cmd_write),
        .ext_cmd_burst(ext_cmd_burst), .ext_cmd_wdata(ext_cmd_wdata),
        .ext_rvalid(ext_rvalid), .ext_rdata(ext_rdata)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int n_single = 0, n_multi = 0, n_wr = 0;
    logic [31:0] last_multi_addr = '0;
    logic [31:0] mem [int unsigned];
    logic [31:0] exp_q [$];
    string       req_q [$];
    int          last_wait;
    bit          finished = 1'b0;

    // External memory model: written words, else a pattern of the address
    function automatic logic [31:0] mem_rd(logic [31:0] a);
        if (mem.exists(a[31:2])) return mem[a[31:2]];
        return {~a[15:0], a[15:0]} ^ 32'h3C5A_0000;
    endfunction

    task automatic check(bit ok, string req, int act, int exp_v);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
        end
    endtask

    // External responder: accepts a command, then returns the beats it needs
    initial begin
        forever begin
            @(posedge clk); #1;
            if (rst_n && ext_cmd_valid) begin
                logic [31:0] a, wd;
                logic        w, b;
                a = ext_cmd_addr; w = ext_cmd_write; b = ext_cmd_burst;
                wd = ext_cmd_wdata;
                ext_cmd_ready = 1'b1;
                @(posedge clk); #1;
                ext_cmd_ready = 1'b0;
                if (w) begin
                    mem[a[31:2]] = wd;
                    n_wr++;
                end else begin
                    int beats;
                    beats = b ? 16 : 1;
                    if (b) begin n_multi++; last_multi_addr = a; end
                    else n_single++;
                    for (int k = 0; k < beats; k++) begin
                        ext_rvalid = 1'b1;
                        ext_rdata  = mem_rd(a + 32'(4*k));
                        @(posedge clk); #1;
                    end
                    ext_rvalid = 1'b0;
                end
            end
        end
    end

    // Scoreboard monitor: compares each read completion with the queue head
    always @(negedge clk) begin
        if (rst_n && loc_valid && loc_ready && !loc_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R9 unexpected-read", loc_rdata, 0);
            end else begin
                logic [31:0] e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                check(loc_rdata == e, r, loc_rdata, e);
            end
        end
    end

    // Driver: hold a request until acknowledged, then release it
    task automatic issue(logic we, logic [31:0] a, logic [31:0] d, logic p);
        @(posedge clk); #2;
        loc_valid = 1'b1; loc_we = we; loc_addr = a; loc_wdata = d; loc_pref = p;
        last_wait = 0;
        do begin
            @(negedge clk);
            last_wait++;
        end while (!loc_ready);
        @(posedge clk); #2;
        loc_valid = 1'b0; loc_we = 1'b0;
    endtask

    task automatic rd(logic [31:0] a, logic p, string req);
        exp_q.push_back(mem_rd(a));
        req_q.push_back(req);
        issue(1'b0, a, '0, p);
    endtask

    task automatic wr(logic [31:0] a, logic [31:0] d, logic p);
        issue(1'b1, a, d, p);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int m0, s0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: quiet ports during reset
        check(!ext_cmd_valid && !loc_ready, "R10 reset-quiet", {ext_cmd_valid, loc_ready}, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;

        // R3 / R10: first prefetchable read misses an empty buffer, fetches aligned line
        rd(32'h0000_1024, 1'b1, "R9 fill-data");
        check(n_multi == 1, "R3 miss-multi", n_multi, 1);
        check(last_multi_addr == 32'h0000_1000, "R3 aligned", last_multi_addr, 32'h1000);
        check(n_single == 0, "R3 no-single", n_single, 0);

        // R5 / R9: eight 64-bit reads over the line, one fetch in total
        for (int i = 0; i < 16; i++) rd(32'h0000_1000 + 32'(4*i), 1'b1, "R9 line-word");
        check(n_multi == 1, "R5 one-multi", n_multi, 1);
        check(n_single == 0, "R5 no-single", n_single, 0);

        // R4: a hit acknowledges on its first cycle
        rd(32'h0000_103C, 1'b1, "R4 hit-data");
        check(last_wait == 1, "R4 hit-latency", last_wait, 1);

        // R2: a non-prefetchable read of a buffered word goes external
        s0 = n_single; m0 = n_multi;
        rd(32'h0000_1008, 1'b0, "R2 nopref-data");
        check(n_single == s0 + 1, "R2 nopref-single", n_single, s0 + 1);
        rd(32'h0000_1008, 1'b1, "R2 still-hit");
        check(n_multi == m0, "R2 line-kept", n_multi, m0);

        // R1: a 64-bit non-prefetchable read costs two single-beat reads
        s0 = n_single;
        rd(32'h0000_2000, 1'b0, "R1 low-word");
        rd(32'h0000_2004, 1'b0, "R1 high-word");
        check(n_single == s0 + 2, "R1 two-singles", n_single, s0 + 2);
        check(n_multi == m0, "R1 no-multi", n_multi, m0);

        // R6: a read in another line replaces the buffer; going back refetches
        rd(32'h0000_3018, 1'b1, "R6 new-line");
        check(n_multi == m0 + 1, "R6 replace", n_multi, m0 + 1);
        check(last_multi_addr == 32'h0000_3000, "R6 replace-addr", last_multi_addr, 32'h3000);
        rd(32'h0000_1004, 1'b1, "R6 back");
        check(n_multi == m0 + 2, "R6 refetch", n_multi, m0 + 2);

        // R8: a write outside the line keeps it valid
        m0 = n_multi;
        wr(32'h0000_5000, 32'hDEAD_0001, 1'b1);
        check(n_wr == 1, "R8 write-out", n_wr, 1);
        rd(32'h0000_1004, 1'b1, "R8 hit-data");
        check(n_multi == m0, "R8 still-hit", n_multi, m0);
        check(last_wait == 1, "R8 hit-latency", last_wait, 1);

        // R7: a write into the line invalidates it; next read sees new data
        wr(32'h0000_1010, 32'hBEEF_CAFE, 1'b1);
        check(n_wr == 2, "R7 write-cmd", n_wr, 2);
        rd(32'h0000_1010, 1'b1, "R7 new-data");
        check(n_multi == m0 + 1, "R7 refill", n_multi, m0 + 1);
        check(mem_rd(32'h0000_1010) == 32'hBEEF_CAFE, "R7 mem", mem_rd(32'h1010), 32'hBEEF_CAFE);

        // R1: single read of the other written word returns it
        rd(32'h0000_5000, 1'b0, "R1 written-word");

        repeat (4) @(posedge clk);
        check(exp_q.size() == 0, "R9 all-read", exp_q.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule